// File: doc/BRIEF.md
# DMA-Activity Access Guard

This block sits between a host access port and the chip selects of three peripheral targets: the DMA controller's register file, the LPC I/O space and the LPC memory space. It watches two activity inputs: one says that the DMA controller is moving data, and the other says that an LPC DMA transfer is under way. While a relevant transfer is active, it allows a read or write to reach its target only if software has set the matching enable bit in the guard's control register. Each target has separate enable bits for reads and for writes.

An access that is not allowed never reaches the device. The chip select and the write strobe stay low, the write data is replaced by zero, and a read returns all ones. The blocked access can also raise a one-cycle trap pulse and a one-cycle error pulse, each gated by its own enable input. A sticky flag records that a block has occurred, and software clears it by writing 1 to the guard's status register. The guard's own control and status registers are always reachable, so software can change the enables in the middle of a transfer. One example is setting the DMA-write enable so that it can abort a hung transfer.

Top module: `dma_access_guard`

## Requirements
- R1: After a synchronous reset, the control register reads 0, the sticky flag is 0, and all chip selects, the write strobe, the response valid and both pulses are low.
- R2: Target code 0 is the control register. Only bits 17, 16 and 3..0 hold a written value, and every other bit reads 0. Accesses to target codes 0 and 1 are never blocked, whatever the activity inputs and the enables hold.
- R3: Target code 2 is the DMA controller. While `dma_xfer_active` is high, a write to it is forwarded only if control bit 17 is 1, and is blocked otherwise.
- R4: While `dma_xfer_active` is high, a read of target 2 is forwarded only if control bit 16 is 1.
- R5: Target code 3 is LPC I/O and target code 4 is LPC memory. While `lpc_dma_active` is high, I/O writes need bit 3, I/O reads need bit 2, memory writes need bit 1 and memory reads need bit 0.
- R6: When the activity input for a target is low, every access to that target is forwarded, whatever the enables hold. `dma_xfer_active` has no effect on targets 3 and 4, and `lpc_dma_active` has no effect on target 2.
- R7: A blocked access leaves all chip selects and `dev_we` low, and drives `dev_wdata` to 0.
- R8: A blocked read gives `rsp_valid` with `rsp_rdata` = 0xFFFFFFFF.
- R9: One cycle after a blocked request, `trap_pulse` equals `trap_enable` and `error_pulse` equals `error_enable`, both as sampled with the request. Neither pulse is ever high in any other cycle.
- R10: Target code 1 is the status register, and it reads the sticky block flag in bit 0, with 0 in all other bits. A block sets the flag. A write with data bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged.
- R11: One cycle after an allowed device request, exactly one chip select is high: `dev_cs[0]` for target 2, `dev_cs[1]` for target 3 and `dev_cs[2]` for target 4. For a write, `dev_we` is 1 and `dev_wdata` carries the request data. For a read, `rsp_valid` is 1 and `rsp_rdata` follows `dev_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 3 | 0 control, 1 status, 2 DMA controller, 3 LPC I/O, 4 LPC memory |
| req_wdata | input | 32 | Write data |
| dma_xfer_active | input | 1 | DMA controller data transfer in progress |
| lpc_dma_active | input | 1 | LPC DMA transfer in progress |
| trap_enable | input | 1 | Allows a trap pulse on a block |
| error_enable | input | 1 | Allows an error pulse on a block |
| dev_rdata | input | 32 | Read data from the selected device during its chip-select cycle |
| dev_cs | output | 3 | Registered chip selects for the three devices |
| dev_we | output | 1 | Registered write strobe to the device |
| dev_wdata | output | 32 | Registered write data to the device |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| trap_pulse | output | 1 | One-cycle trap indication on a block |
| error_pulse | output | 1 | One-cycle error indication on a block |
| blocked_flag | output | 1 | Sticky block flag |

## Verification
The bound checker checks some rules on every cycle. These are the lock-out of DMA-controller reads and writes when their bits are clear, pass-through when an activity input is low, the one-hot chip selects, the gating of the pulses by their enables, zero reserved bits in control readback, and the flag rising only after a device request. Other behaviour can only be shown by the bench's sweeps. The sweeps cover every one of the 64 enable patterns, crossed with all three device targets, both directions and all four activity combinations, with the expected result computed from the bit map. That is where the bench shows the LPC bit mapping, the exact write data and read data that are forwarded, and the write-one-to-clear behaviour of the sticky flag.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int NDEV      = 3;
  localparam int FIRST_DEV = 2;
  localparam int TGT_W     = 3;

  typedef enum logic [TGT_W-1:0] {
    TGT_CTRL   = 3'd0,
    TGT_STAT   = 3'd1,
    TGT_DMAC   = 3'd2,
    TGT_LPCIO  = 3'd3,
    TGT_LPCMEM = 3'd4
  } tgt_e;

  // Control bit that permits writes to device d during activity
  function automatic int wr_pos(int d);
    case (d)
      0:       return 17;
      1:       return 3;
      default: return 1;
    endcase
  endfunction

  // Control bit that permits reads of device d during activity
  function automatic int rd_pos(int d);
    case (d)
      0:       return 16;
      1:       return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dag_ctrl_regs.sv
module dag_ctrl_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          set_block,
  output logic [DW-1:0] ctrl,
  output logic          sticky
);
  import dag_pkg::*;

  localparam logic [DW-1:0] WMASK = (DW'(1) << wr_pos(0)) | (DW'(1) << rd_pos(0)) |
                                    (DW'(1) << wr_pos(1)) | (DW'(1) << rd_pos(1)) |
                                    (DW'(1) << wr_pos(2)) | (DW'(1) << rd_pos(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      sticky <= 1'b0;
    end else begin
      if (wr_ctrl)
        ctrl <= wdata & WMASK;
      if (set_block)
        sticky <= 1'b1;
      else if (wr_stat && wdata[0])
        sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/dag_policy.sv
module dag_policy #(
  parameter int DW = 32
) (
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [dag_pkg::TGT_W-1:0]   req_target,
  input  logic [DW-1:0]               ctrl,
  input  logic                        dma_act,
  input  logic                        lpc_act,
  output logic [dag_pkg::NDEV-1:0]    dev_hit,
  output logic                        blocked,
  output logic                        pass
);
  import dag_pkg::*;

  logic [NDEV-1:0] lock;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    logic act;
    logic en;
    assign dev_hit[g] = req_valid && (req_target == TGT_W'(FIRST_DEV + g));
    if (g == 0) begin : g_dmac
      assign act = dma_act;
    end else begin : g_lpc
      assign act = lpc_act;
    end
    assign en      = req_write ? ctrl[wr_pos(g)] : ctrl[rd_pos(g)];
    assign lock[g] = dev_hit[g] & act & ~en;
  end

  assign blocked = |lock;
  assign pass    = (|dev_hit) & ~blocked;
endmodule

// File: rtl/dag_resp.sv
module dag_resp #(
  parameter int DW   = 32,
  parameter int NDEV = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  input  logic [NDEV-1:0] dev_hit,
  input  logic            pass,
  input  logic            blocked,
  input  logic            local_hit,
  input  logic [DW-1:0]   local_rdata,
  input  logic [DW-1:0]   dev_rdata,
  input  logic            trap_enable,
  input  logic            error_enable,
  output logic [NDEV-1:0] dev_cs,
  output logic            dev_we,
  output logic [DW-1:0]   dev_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            trap_pulse,
  output logic            error_pulse
);
  logic          from_dev_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_cs      <= '0;
      dev_we      <= 1'b0;
      dev_wdata   <= '0;
      rsp_valid   <= 1'b0;
      from_dev_q  <= 1'b0;
      rdata_q     <= '0;
      trap_pulse  <= 1'b0;
      error_pulse <= 1'b0;
    end else begin
      dev_cs      <= pass ? dev_hit : '0;
      dev_we      <= pass & req_write;
      dev_wdata   <= (pass & req_write) ? req_wdata : '0;
      rsp_valid   <= req_valid & ~req_write;
      from_dev_q  <= pass & ~req_write;
      rdata_q     <= blocked ? '1 : (local_hit ? local_rdata : '0);
      trap_pulse  <= blocked & trap_enable;
      error_pulse <= blocked & error_enable;
    end
  end

  assign rsp_rdata = from_dev_q ? dev_rdata : rdata_q;
endmodule

// File: rtl/dma_access_guard.sv
module dma_access_guard #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_target,
  input  logic [DW-1:0] req_wdata,
  input  logic          dma_xfer_active,
  input  logic          lpc_dma_active,
  input  logic          trap_enable,
  input  logic          error_enable,
  input  logic [DW-1:0] dev_rdata,
  output logic [2:0]    dev_cs,
  output logic          dev_we,
  output logic [DW-1:0] dev_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          trap_pulse,
  output logic          error_pulse,
  output logic          blocked_flag
);
  import dag_pkg::*;

  logic [DW-1:0]   ctrl_q;
  logic            sticky_q;
  logic [NDEV-1:0] dev_hit;
  logic            blocked;
  logic            pass;
  logic            hit_ctrl;
  logic            hit_stat;
  logic [DW-1:0]   local_rdata;

  assign hit_ctrl    = req_target == TGT_CTRL;
  assign hit_stat    = req_target == TGT_STAT;
  assign local_rdata = hit_ctrl ? ctrl_q : {{(DW-1){1'b0}}, sticky_q};

  dag_ctrl_regs #(.DW(DW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (req_valid & req_write & hit_ctrl),
    .wr_stat   (req_valid & req_write & hit_stat),
    .wdata     (req_wdata),
    .set_block (blocked),
    .ctrl      (ctrl_q),
    .sticky    (sticky_q)
  );

  dag_policy #(.DW(DW)) policy_i (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_target (req_target),
    .ctrl       (ctrl_q),
    .dma_act    (dma_xfer_active),
    .lpc_act    (lpc_dma_active),
    .dev_hit    (dev_hit),
    .blocked    (blocked),
    .pass       (pass)
  );

  dag_resp #(.DW(DW), .NDEV(NDEV)) resp_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_wdata    (req_wdata),
    .dev_hit      (dev_hit),
    .pass         (pass),
    .blocked      (blocked),
    .local_hit    (hit_ctrl | hit_stat),
    .local_rdata  (local_rdata),
    .dev_rdata    (dev_rdata),
    .trap_enable  (trap_enable),
    .error_enable (error_enable),
    .dev_cs       (dev_cs),
    .dev_we       (dev_we),
    .dev_wdata    (dev_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .trap_pulse   (trap_pulse),
    .error_pulse  (error_pulse)
  );

  assign blocked_flag = sticky_q;
endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [2:0]    req_target,
  input logic          dma_xfer_active,
  input logic          lpc_dma_active,
  input logic          trap_enable,
  input logic          error_enable,
  input logic [DW-1:0] ctrl,
  input logic [2:0]    dev_cs,
  input logic          dev_we,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          trap_pulse,
  input logic          error_pulse,
  input logic          blocked_flag
);
  localparam logic [DW-1:0] KEEP = (DW'(1) << 17) | (DW'(1) << 16) | DW'(15);

  // R3
  dmac_wr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_target == 3'd2 && dma_xfer_active && !ctrl[17])
      |=> (!dev_cs[0] && !dev_we));

  // R4
  dmac_rd_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_target == 3'd2 && dma_xfer_active && !ctrl[16])
      |=> (rsp_valid && rsp_rdata == '1 && dev_cs == 3'b000));

  // R6
  lpc_idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == 3'd3 && !lpc_dma_active) |=> dev_cs[1]);

  // R6
  dma_idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == 3'd2 && !dma_xfer_active) |=> dev_cs[0]);

  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_cs));

  // R9
  trap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    trap_pulse |-> ($past(trap_enable) && $past(req_valid)));

  // R9
  err_gate_chk: assert property (@(posedge clk) disable iff (rst)
    error_pulse |-> ($past(error_enable) && $past(req_valid)));

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_target == 3'd0)
      |=> (rsp_valid && (rsp_rdata & ~KEEP) == '0));

  // R10
  sticky_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(blocked_flag) |-> ($past(req_valid) && $past(req_target) >= 3'd2 && $past(req_target) <= 3'd4));
endmodule

bind dma_access_guard dag_checker #(.DW(DW)) chk_i (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .req_target      (req_target),
  .dma_xfer_active (dma_xfer_active),
  .lpc_dma_active  (lpc_dma_active),
  .trap_enable     (trap_enable),
  .error_enable    (error_enable),
  .ctrl            (ctrl_q),
  .dev_cs          (dev_cs),
  .dev_we          (dev_we),
  .rsp_valid       (rsp_valid),
  .rsp_rdata       (rsp_rdata),
  .trap_pulse      (trap_pulse),
  .error_pulse     (error_pulse),
  .blocked_flag    (blocked_flag)
);

// File: tb/dma_access_guard_tb_top.sv
`timescale 1ns/1ps
module dma_access_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_target = 3'd0;
  logic [31:0] req_wdata = '0;
  logic        dma_xfer_active = 1'b0;
  logic        lpc_dma_active = 1'b0;
  logic        trap_enable = 1'b0;
  logic        error_enable = 1'b0;
  logic [31:0] dev_rdata = '0;
  logic [2:0]  dev_cs;
  logic        dev_we;
  logic [31:0] dev_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        trap_pulse;
  logic        error_pulse;
  logic        blocked_flag;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit sticky_m = 1'b0;

  always #2 clk = ~clk;

  dma_access_guard #(.DW(32)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .req_wdata(req_wdata),
    .dma_xfer_active(dma_xfer_active), .lpc_dma_active(lpc_dma_active),
    .trap_enable(trap_enable), .error_enable(error_enable), .dev_rdata(dev_rdata),
    .dev_cs(dev_cs), .dev_we(dev_we), .dev_wdata(dev_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .trap_pulse(trap_pulse), .error_pulse(error_pulse),
    .blocked_flag(blocked_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One request cycle; on return, outputs of that request are visible.
  task automatic issue(input bit wr, input logic [2:0] tgt, input logic [31:0] wd);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_target = tgt;
    req_wdata  = wd;
    @(negedge clk);
    req_valid  = 1'b0;
    req_wdata  = '0;
  endtask

  function automatic logic [31:0] ctrl_of(input int e);
    return {14'd0, e[5], e[4], 12'd0, e[3:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dev_cs == 3'b000 && !dev_we && !rsp_valid && !trap_pulse && !error_pulse,
          "R1 idle outputs", {dev_cs, dev_we, rsp_valid, trap_pulse, error_pulse}, 0);
    check(!blocked_flag, "R1 sticky", 32'(blocked_flag), 0);
    issue(1'b0, 3'd0, '0);
    check(rsp_valid && rsp_rdata == 0, "R1 ctrl reset value", rsp_rdata, 0);

    for (int e = 0; e < 64; e++) begin
      logic [31:0] cval;
      cval = ctrl_of(e);
      dma_xfer_active = 1'b1;
      lpc_dma_active  = 1'b1;
      // R2: write with reserved bits set while both transfers active
      issue(1'b1, 3'd0, cval | 32'hFFFC_FFF0);
      check(dev_cs == 0 && !dev_we && !trap_pulse, "R2 ctrl write not forwarded", {29'd0, dev_cs}, 0);
      issue(1'b0, 3'd0, '0);
      check(rsp_valid && rsp_rdata == cval, "R2 ctrl readback", rsp_rdata, cval);

      for (int t = 2; t <= 4; t++) begin
        for (int w = 0; w < 2; w++) begin
          for (int b = 0; b < 4; b++) begin
            int d;
            int pos;
            bit act;
            bit ok_m;
            bit te;
            bit ee;
            logic [31:0] wd;
            logic [31:0] exp_rd;
            d   = t - 2;
            pos = (d == 0) ? (w ? 17 : 16) : (d == 1) ? (w ? 3 : 2) : (w ? 1 : 0);
            dma_xfer_active = b[0];
            lpc_dma_active  = b[1];
            act  = (d == 0) ? b[0] : b[1];
            ok_m = !act || cval[pos];
            te   = ((e + t + b) % 2) == 0;
            ee   = ((e + w + b) % 3) == 0;
            trap_enable  = te;
            error_enable = ee;
            wd        = 32'hA500_0000 ^ (e << 8) ^ (t << 4) ^ b;
            dev_rdata = 32'h5A00_0000 | (e << 12) | (t << 4) | b;
            issue(w[0], 3'(t), wd);
            if (!ok_m) sticky_m = 1'b1;
            if (ok_m) begin
              // R11 / R3 / R4 / R5 / R6 forwarded
              check(dev_cs == 3'(1 << d), "R11 R5 R6 cs on allowed", {29'd0, dev_cs}, 32'(1 << d));
              check(dev_we == w[0] && dev_wdata == (w ? wd : 32'd0), "R11 write path", dev_wdata, w ? wd : 32'd0);
              if (w == 0)
                check(rsp_valid && rsp_rdata == dev_rdata, "R11 R4 read passthrough", rsp_rdata, dev_rdata);
            end else begin
              // R7 / R3 / R4 / R5 blocked
              check(dev_cs == 0 && !dev_we && dev_wdata == 0, "R7 R3 R5 blocked drive", {dev_wdata[27:0], dev_cs, dev_we}, 0);
              if (w == 0)
                check(rsp_valid && rsp_rdata == 32'hFFFF_FFFF, "R8 R4 blocked read", rsp_rdata, 32'hFFFF_FFFF);
            end
            check(trap_pulse == (!ok_m && te) && error_pulse == (!ok_m && ee), "R9 pulses",
                  {30'd0, trap_pulse, error_pulse}, {30'd0, !ok_m && te, !ok_m && ee});
            @(negedge clk);
            check(!trap_pulse && !error_pulse && dev_cs == 0, "R9 pulse single cycle",
                  {29'd0, trap_pulse, error_pulse, |dev_cs}, 0);
          end
        end
      end
      check(blocked_flag == sticky_m, "R10 sticky tracks blocks", 32'(blocked_flag), 32'(sticky_m));
    end

    // R10 status register and write-one-to-clear
    issue(1'b0, 3'd1, '0);
    check(rsp_valid && rsp_rdata == 32'(sticky_m), "R10 status read", rsp_rdata, 32'(sticky_m));
    issue(1'b1, 3'd1, 32'hFFFF_FFFE);
    check(blocked_flag == sticky_m, "R10 write 0 keeps flag", 32'(blocked_flag), 32'(sticky_m));
    issue(1'b1, 3'd1, 32'h0000_0001);
    check(!blocked_flag, "R10 write 1 clears", 32'(blocked_flag), 0);
    issue(1'b0, 3'd1, '0);
    check(rsp_valid && rsp_rdata == 0, "R10 status after clear", rsp_rdata, 0);

    // R1 again: after reset enables are zero, so a DMA write is blocked during activity
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    dma_xfer_active = 1'b1;
    trap_enable = 1'b1;
    issue(1'b1, 3'd2, 32'h1234_5678);
    check(dev_cs == 0 && !dev_we && trap_pulse, "R1 R3 locked after reset", {29'd0, dev_cs}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule